// File: doc/BRIEF.md
# Memory Clock Rate Change Sequencer

This block walks a DDR3-style memory device from one stable clock rate to another without breaking the device's timing rules. On a request it checks the target rate against a configured floor. If the rate is acceptable, it parks the device in one of two low-power states, chosen by a path input: self-refresh, or precharge power-down. It does this by dropping CKE, forcing ODT low and emitting an enter command. After a programmable entry delay it tells an external clock generator that the rate may now change.

When the generator reports a stable clock, the block counts a programmable stability delay and raises CKE with an exit command. After the exit delay it emits three mode-register commands: a DLL reset, then the write-recovery/CAS-latency word, then the CAS-write-latency word. It then waits out the DLL lock time before it reports ready again. While the block is idle, ODT follows the controller's normal ODT request and CKE stays high. All delays are cycle counts taken from configuration inputs when each wait begins.

Top module: `freq_shift_seq`

## Requirements
- R1: Out of reset, rdy_o=1, cke_o=1, odt_o=0, clk_chg_ok_o=0, cmd_vld_o=0, ack_o=0 and rej_o=0.
- R2: A request sampled in idle with tgt_freq_i below cfg_min_freq_i yields a one-cycle rej_o pulse on the next cycle. There is no ack_o, no command, cke_o stays 1 and rdy_o stays 1. A target equal to the floor is accepted.
- R3: An accepted request yields, on the next cycle, a one-cycle ack_o together with cmd_vld_o carrying op 0 (enter low power) and cmd_dat_o equal to the path bit in bit 0 and zeros elsewhere. On that same cycle cke_o=0, odt_o=0 and rdy_o=0.
- R4: clk_chg_ok_o rises exactly cfg_t_enter_i+1 cycles after cke_o falls, and never earlier than cfg_t_enter_i cycles after it.
- R5: clk_chg_ok_o is only ever high while cke_o=0 and odt_o=0. cke_o and odt_o stay low from entry until exit.
- R6: clk_chg_ok_o falls on the cycle after clk_stable_i is first sampled high. cke_o rises cfg_t_stable_i+2 cycles after clk_stable_i is raised, provided it stays high. A low sample during that wait raises clk_chg_ok_o again and restarts the count from the next high sample.
- R7: cke_o rises together with a one-cycle command of op 1 (exit low power), whose cmd_dat_o bit 0 is the path bit.
- R8: cfg_t_xp_i+1 cycles after the exit command, three back-to-back commands are emitted. The first is op 2 (DLL reset), with data {2'b00, cfg_mr0_i with bit 8 set}. The second is op 3, with data {2'b00, cfg_mr0_i with bit 8 clear}. The third is op 3, with data {2'b10, cfg_mr2_i}. Bits [15:14] of the data select the mode register.
- R9: During the mode-register commands and the DLL lock wait, cke_o=1 and odt_o=0.
- R10: rdy_o rises cfg_t_lock_i+1 cycles after the last mode-register command, with cke_o=1.
- R11: A request raised while a sequence is running is ignored: no ack_o, and the timing of the running sequence is unchanged.
- R12: In idle, odt_o follows odt_i one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Rate change request |
| path_pd_i | input | 1 | 1 selects precharge power-down, 0 selects self-refresh |
| tgt_freq_i | input | 12 | Target clock rate code |
| cfg_min_freq_i | input | 12 | Lowest permitted rate code |
| cfg_t_enter_i | input | 16 | Entry delay in cycles |
| cfg_t_stable_i | input | 16 | Required stable-clock delay in cycles |
| cfg_t_xp_i | input | 16 | Exit-to-command delay in cycles |
| cfg_t_lock_i | input | 16 | DLL lock delay in cycles |
| cfg_mr0_i | input | 14 | Write recovery / CAS latency register value |
| cfg_mr2_i | input | 14 | CAS write latency register value |
| odt_i | input | 1 | Normal ODT request while idle |
| clk_stable_i | input | 1 | Clock generator reports a stable new clock |
| ack_o | output | 1 | Request accepted pulse |
| rej_o | output | 1 | Request rejected pulse |
| clk_chg_ok_o | output | 1 | Clock rate may be changed now |
| cke_o | output | 1 | Clock enable to the device |
| odt_o | output | 1 | On-die termination control to the device |
| cmd_vld_o | output | 1 | Command strobe |
| cmd_op_o | output | 2 | Command op: 0 enter, 1 exit, 2 DLL reset, 3 timing register write |
| cmd_dat_o | output | 16 | Command data field |
| rdy_o | output | 1 | Device ready at the current clock rate |

## Verification
On every cycle, the assertions check three level rules: the permission to change the clock only while CKE and ODT are low, the entry and stability minimums measured with their own counters, and CKE high with ODT low around every mode-register command. The exact cycle counts of each wait, the contents and order of the three mode-register words, the restart when the clock loses stability, and the ignoring of a request during a running sequence are shown only by the bench's scenarios. Rejection at and just below the rate floor, and zero-length delays, are likewise shown only by those scenarios.

// File: rtl/fshift_pkg.sv
package fshift_pkg;

    localparam int DLL_RST_BIT = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER_WAIT,
        ST_CLK_CHG,
        ST_STABLE_WAIT,
        ST_XP_WAIT,
        ST_MRS_TIM0,
        ST_MRS_TIM1,
        ST_LOCK_WAIT
    } fs_state_e;

    typedef enum logic [1:0] {
        OP_ENTER   = 2'd0,
        OP_EXIT    = 2'd1,
        OP_DLL_RST = 2'd2,
        OP_MRS_TIM = 2'd3
    } fs_op_e;

    typedef struct packed {
        fs_state_e st;
        logic      cke;
        logic      odt;
        logic      chg_ok;
        logic      cmd_vld;
        fs_op_e    op;
        logic      mr_sel;
        logic      path;
        logic      ack;
        logic      rej;
        logic      rdy;
    } fs_regs_t;

endpackage

// File: rtl/fshift_req_gate.sv
module fshift_req_gate #(
    parameter int FREQ_W = 12
) (
    input  logic [FREQ_W-1:0] tgt_i,
    input  logic [FREQ_W-1:0] floor_i,
    output logic              ok_o
);
    always_comb begin
        ok_o = (tgt_i >= floor_i);
    end
endmodule

// File: rtl/fshift_delay.sv
module fshift_delay #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic         en_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_i) begin
            cnt_d = ld_val_i;
        end else if (en_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/fshift_cmd_fmt.sv
module fshift_cmd_fmt #(
    parameter int MR_W = 14,
    localparam int DAT_W = MR_W + 2
) (
    input  fshift_pkg::fs_op_e op_i,
    input  logic               path_i,
    input  logic               mr_sel_i,
    input  logic [MR_W-1:0]    mr0_i,
    input  logic [MR_W-1:0]    mr2_i,
    output logic [DAT_W-1:0]   dat_o
);
    import fshift_pkg::*;

    localparam logic [MR_W-1:0] DLL_MASK = MR_W'(1) << DLL_RST_BIT;

    always_comb begin
        dat_o = '0;
        unique case (op_i)
            OP_ENTER, OP_EXIT: dat_o[0] = path_i;
            OP_DLL_RST:        dat_o = {2'b00, mr0_i | DLL_MASK};
            OP_MRS_TIM: begin
                if (mr_sel_i) begin
                    dat_o = {2'b10, mr2_i};
                end else begin
                    dat_o = {2'b00, mr0_i & ~DLL_MASK};
                end
            end
            default:           dat_o = '0;
        endcase
    end
endmodule

// File: rtl/freq_shift_seq.sv
module freq_shift_seq #(
    parameter int FREQ_W = 12,
    parameter int CNT_W  = 16,
    parameter int MR_W   = 14,
    localparam int DAT_W = MR_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              path_pd_i,
    input  logic [FREQ_W-1:0] tgt_freq_i,
    input  logic [FREQ_W-1:0] cfg_min_freq_i,
    input  logic [CNT_W-1:0]  cfg_t_enter_i,
    input  logic [CNT_W-1:0]  cfg_t_stable_i,
    input  logic [CNT_W-1:0]  cfg_t_xp_i,
    input  logic [CNT_W-1:0]  cfg_t_lock_i,
    input  logic [MR_W-1:0]   cfg_mr0_i,
    input  logic [MR_W-1:0]   cfg_mr2_i,
    input  logic              odt_i,
    input  logic              clk_stable_i,
    output logic              ack_o,
    output logic              rej_o,
    output logic              clk_chg_ok_o,
    output logic              cke_o,
    output logic              odt_o,
    output logic              cmd_vld_o,
    output logic [1:0]        cmd_op_o,
    output logic [DAT_W-1:0]  cmd_dat_o,
    output logic              rdy_o
);
    import fshift_pkg::*;

    fs_regs_t           r_d, r_q;
    logic               tgt_ok;
    logic               tmr_ld;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_en;
    logic               tmr_zero;

    fshift_req_gate #(.FREQ_W(FREQ_W)) u_gate (
        .tgt_i   (tgt_freq_i),
        .floor_i (cfg_min_freq_i),
        .ok_o    (tgt_ok)
    );

    fshift_delay #(.W(CNT_W)) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (tmr_ld),
        .ld_val_i (tmr_val),
        .en_i     (tmr_en),
        .zero_o   (tmr_zero)
    );

    fshift_cmd_fmt #(.MR_W(MR_W)) u_fmt (
        .op_i     (r_q.op),
        .path_i   (r_q.path),
        .mr_sel_i (r_q.mr_sel),
        .mr0_i    (cfg_mr0_i),
        .mr2_i    (cfg_mr2_i),
        .dat_o    (cmd_dat_o)
    );

    always_comb begin
        r_d         = r_q;
        r_d.ack     = 1'b0;
        r_d.rej     = 1'b0;
        r_d.cmd_vld = 1'b0;
        tmr_ld      = 1'b0;
        tmr_val     = '0;
        tmr_en      = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cke = 1'b1;
                r_d.odt = odt_i;
                if (req_i) begin
                    if (tgt_ok) begin
                        r_d.ack     = 1'b1;
                        r_d.rdy     = 1'b0;
                        r_d.cmd_vld = 1'b1;
                        r_d.op      = OP_ENTER;
                        r_d.path    = path_pd_i;
                        r_d.cke     = 1'b0;
                        r_d.odt     = 1'b0;
                        tmr_ld      = 1'b1;
                        tmr_val     = cfg_t_enter_i;
                        r_d.st      = ST_ENTER_WAIT;
                    end else begin
                        r_d.rej = 1'b1;
                    end
                end
            end
            ST_ENTER_WAIT: begin
                tmr_en = 1'b1;
                if (tmr_zero) begin
                    r_d.chg_ok = 1'b1;
                    r_d.st     = ST_CLK_CHG;
                end
            end
            ST_CLK_CHG: begin
                if (clk_stable_i) begin
                    r_d.chg_ok = 1'b0;
                    tmr_ld     = 1'b1;
                    tmr_val    = cfg_t_stable_i;
                    r_d.st     = ST_STABLE_WAIT;
                end
            end
            ST_STABLE_WAIT: begin
                if (!clk_stable_i) begin
                    r_d.chg_ok = 1'b1;
                    r_d.st     = ST_CLK_CHG;
                end else if (tmr_zero) begin
                    r_d.cke     = 1'b1;
                    r_d.cmd_vld = 1'b1;
                    r_d.op      = OP_EXIT;
                    tmr_ld      = 1'b1;
                    tmr_val     = cfg_t_xp_i;
                    r_d.st      = ST_XP_WAIT;
                end else begin
                    tmr_en = 1'b1;
                end
            end
            ST_XP_WAIT: begin
                tmr_en = 1'b1;
                if (tmr_zero) begin
                    r_d.cmd_vld = 1'b1;
                    r_d.op      = OP_DLL_RST;
                    r_d.mr_sel  = 1'b0;
                    r_d.st      = ST_MRS_TIM0;
                end
            end
            ST_MRS_TIM0: begin
                r_d.cmd_vld = 1'b1;
                r_d.op      = OP_MRS_TIM;
                r_d.mr_sel  = 1'b0;
                r_d.st      = ST_MRS_TIM1;
            end
            ST_MRS_TIM1: begin
                r_d.cmd_vld = 1'b1;
                r_d.op      = OP_MRS_TIM;
                r_d.mr_sel  = 1'b1;
                tmr_ld      = 1'b1;
                tmr_val     = cfg_t_lock_i;
                r_d.st      = ST_LOCK_WAIT;
            end
            ST_LOCK_WAIT: begin
                tmr_en = 1'b1;
                if (tmr_zero) begin
                    r_d.rdy = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.cke     <= 1'b1;
            r_q.odt     <= 1'b0;
            r_q.chg_ok  <= 1'b0;
            r_q.cmd_vld <= 1'b0;
            r_q.op      <= OP_ENTER;
            r_q.mr_sel  <= 1'b0;
            r_q.path    <= 1'b0;
            r_q.ack     <= 1'b0;
            r_q.rej     <= 1'b0;
            r_q.rdy     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o        = r_q.ack;
    assign rej_o        = r_q.rej;
    assign clk_chg_ok_o = r_q.chg_ok;
    assign cke_o        = r_q.cke;
    assign odt_o        = r_q.odt;
    assign cmd_vld_o    = r_q.cmd_vld;
    assign cmd_op_o     = r_q.op;
    assign rdy_o        = r_q.rdy;
endmodule

// File: rtl/fshift_chk.sv
module fshift_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack_o,
    input logic             rej_o,
    input logic             clk_chg_ok_o,
    input logic             cke_o,
    input logic             odt_o,
    input logic             cmd_vld_o,
    input logic [1:0]       cmd_op_o,
    input logic             rdy_o,
    input logic             clk_stable_i,
    input logic [CNT_W-1:0] cfg_t_enter_i,
    input logic [CNT_W-1:0] cfg_t_stable_i
);
    logic [CNT_W:0] low_cnt_q;
    logic [CNT_W:0] stab_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || cke_o) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != '1) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !clk_stable_i) begin
            stab_cnt_q <= '0;
        end else if (stab_cnt_q != '1) begin
            stab_cnt_q <= stab_cnt_q + 1'b1;
        end
    end

    a_r2_reject_alone: assert property (@(posedge clk) disable iff (!rst_n)
        rej_o |-> (!ack_o && !cmd_vld_o && rdy_o && cke_o));

    a_r3_ack_enters: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (cmd_vld_o && cmd_op_o == 2'd0 && !cke_o && !odt_o && !rdy_o));

    a_r4_enter_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_chg_ok_o) |-> (low_cnt_q >= {1'b0, cfg_t_enter_i}));

    a_r5_change_in_low_power: assert property (@(posedge clk) disable iff (!rst_n)
        clk_chg_ok_o |-> (!cke_o && !odt_o));

    a_r6_stable_before_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_o) |-> (stab_cnt_q >= {1'b0, cfg_t_stable_i}));

    a_r7_exit_with_cke: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && cmd_op_o == 2'd1) |-> $rose(cke_o));

    a_r9_mrs_levels: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && cmd_op_o[1]) |-> (cke_o && !odt_o && !clk_chg_ok_o));

    a_r10_ready_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> (cke_o && !clk_chg_ok_o));
endmodule

bind freq_shift_seq fshift_chk #(.CNT_W(CNT_W)) u_fshift_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ack_o          (ack_o),
    .rej_o          (rej_o),
    .clk_chg_ok_o   (clk_chg_ok_o),
    .cke_o          (cke_o),
    .odt_o          (odt_o),
    .cmd_vld_o      (cmd_vld_o),
    .cmd_op_o       (cmd_op_o),
    .rdy_o          (rdy_o),
    .clk_stable_i   (clk_stable_i),
    .cfg_t_enter_i  (cfg_t_enter_i),
    .cfg_t_stable_i (cfg_t_stable_i)
);

// File: tb/freq_shift_seq_bench.sv
module freq_shift_seq_bench;

    typedef struct packed {
        logic [11:0] tgt;
        logic        path;
        logic [7:0]  ten;
        logic [7:0]  tsx;
        logic [7:0]  txp;
        logic [7:0]  tlk;
        logic        rej;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{tgt: 12'd800,  path: 1'b1, ten: 8'd3, tsx: 8'd4, txp: 8'd2, tlk: 8'd6,  rej: 1'b0},
        '{tgt: 12'd299,  path: 1'b0, ten: 8'd3, tsx: 8'd4, txp: 8'd2, tlk: 8'd6,  rej: 1'b1},
        '{tgt: 12'd300,  path: 1'b0, ten: 8'd0, tsx: 8'd0, txp: 8'd0, tlk: 8'd0,  rej: 1'b0},
        '{tgt: 12'd1066, path: 1'b0, ten: 8'd5, tsx: 8'd1, txp: 8'd7, tlk: 8'd10, rej: 1'b0},
        '{tgt: 12'd0,    path: 1'b1, ten: 8'd2, tsx: 8'd2, txp: 8'd2, tlk: 8'd2,  rej: 1'b1}
    };

    localparam logic [13:0] MR0 = 14'h0a34;
    localparam logic [13:0] MR2 = 14'h0018;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        path_pd_i = 1'b0;
    logic [11:0] tgt_freq_i = '0;
    logic [11:0] cfg_min_freq_i = 12'd300;
    logic [15:0] cfg_t_enter_i = '0;
    logic [15:0] cfg_t_stable_i = '0;
    logic [15:0] cfg_t_xp_i = '0;
    logic [15:0] cfg_t_lock_i = '0;
    logic [13:0] cfg_mr0_i = MR0;
    logic [13:0] cfg_mr2_i = MR2;
    logic        odt_i = 1'b0;
    logic        clk_stable_i = 1'b0;
    logic        ack_o, rej_o, clk_chg_ok_o, cke_o, odt_o, cmd_vld_o, rdy_o;
    logic [1:0]  cmd_op_o;
    logic [15:0] cmd_dat_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    freq_shift_seq u_freq_shift_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .path_pd_i(path_pd_i),
        .tgt_freq_i(tgt_freq_i), .cfg_min_freq_i(cfg_min_freq_i),
        .cfg_t_enter_i(cfg_t_enter_i), .cfg_t_stable_i(cfg_t_stable_i),
        .cfg_t_xp_i(cfg_t_xp_i), .cfg_t_lock_i(cfg_t_lock_i),
        .cfg_mr0_i(cfg_mr0_i), .cfg_mr2_i(cfg_mr2_i), .odt_i(odt_i),
        .clk_stable_i(clk_stable_i), .ack_o(ack_o), .rej_o(rej_o),
        .clk_chg_ok_o(clk_chg_ok_o), .cke_o(cke_o), .odt_o(odt_o),
        .cmd_vld_o(cmd_vld_o), .cmd_op_o(cmd_op_o), .cmd_dat_o(cmd_dat_o),
        .rdy_o(rdy_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog act %0d exp below 50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic wait_for(input int which, output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            n = n + 1;
            if (which == 0 && clk_chg_ok_o) break;
            if (which == 1 && cke_o) break;
            if (which == 2 && cmd_vld_o) break;
            if (which == 3 && rdy_o) break;
        end
    endtask

    task automatic run_seq(input vec_t v, input bit poke_busy, input bit drop_stable);
        int n;
        tgt_freq_i     = v.tgt;
        path_pd_i      = v.path;
        cfg_t_enter_i  = 16'(v.ten);
        cfg_t_stable_i = 16'(v.tsx);
        cfg_t_xp_i     = 16'(v.txp);
        cfg_t_lock_i   = 16'(v.tlk);
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        if (v.rej) begin
            chk(rej_o && !ack_o && !cmd_vld_o, "R2 reject pulse", {rej_o, ack_o, cmd_vld_o}, 4);
            chk(cke_o && rdy_o, "R2 cke/rdy kept", {cke_o, rdy_o}, 3);
            @(negedge clk);
            chk(!rej_o, "R2 single pulse", rej_o, 0);
            return;
        end
        chk(ack_o && cmd_vld_o && cmd_op_o == 2'd0, "R3 enter cmd", {ack_o, cmd_vld_o, cmd_op_o}, 12);
        chk(cmd_dat_o == {15'd0, v.path}, "R3 enter data", cmd_dat_o, v.path);
        chk(!cke_o && !odt_o && !rdy_o, "R3 levels", {cke_o, odt_o, rdy_o}, 0);
        if (poke_busy) begin
            req_i = 1'b1;
            @(negedge clk);
            req_i = 1'b0;
            chk(!ack_o, "R11 busy ignored", ack_o, 0);
            wait_for(0, n);
            n = n + 1;
        end else begin
            wait_for(0, n);
        end
        chk(n == v.ten + 1, "R4 chg_ok delay", n, v.ten + 1);
        repeat (3) @(negedge clk);
        chk(!cke_o && !odt_o && clk_chg_ok_o, "R5 held low", {cke_o, odt_o, clk_chg_ok_o}, 1);
        clk_stable_i = 1'b1;
        @(negedge clk);
        chk(!clk_chg_ok_o, "R6 chg_ok falls", clk_chg_ok_o, 0);
        if (drop_stable) begin
            clk_stable_i = 1'b0;
            @(negedge clk);
            chk(clk_chg_ok_o && !cke_o, "R6 restart", {clk_chg_ok_o, cke_o}, 2);
            clk_stable_i = 1'b1;
            wait_for(1, n);
        end else begin
            wait_for(1, n);
            n = n + 1;
        end
        chk(n == v.tsx + 2, "R6 exit delay", n, v.tsx + 2);
        chk(cmd_vld_o && cmd_op_o == 2'd1 && cmd_dat_o == {15'd0, v.path}, "R7 exit cmd", {cmd_op_o, cmd_dat_o}, {2'd1, 15'd0, v.path});
        wait_for(2, n);
        chk(n == v.txp + 1, "R8 xp delay", n, v.txp + 1);
        chk(cmd_op_o == 2'd2 && cmd_dat_o == 16'h0b34, "R8 dll reset", {cmd_op_o, cmd_dat_o}, {2'd2, 16'h0b34});
        @(negedge clk);
        chk(cmd_vld_o && cmd_op_o == 2'd3 && cmd_dat_o == 16'h0a34, "R8 timing word 0", {cmd_op_o, cmd_dat_o}, {2'd3, 16'h0a34});
        @(negedge clk);
        chk(cmd_vld_o && cmd_op_o == 2'd3 && cmd_dat_o == 16'h8018, "R8 timing word 2", {cmd_op_o, cmd_dat_o}, {2'd3, 16'h8018});
        chk(cke_o && !odt_o, "R9 mrs levels", {cke_o, odt_o}, 2);
        wait_for(3, n);
        chk(n == v.tlk + 1, "R10 lock delay", n, v.tlk + 1);
        chk(cke_o && !odt_o, "R9 lock levels", {cke_o, odt_o}, 2);
        clk_stable_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rdy_o && cke_o && !odt_o && !clk_chg_ok_o && !cmd_vld_o && !ack_o && !rej_o,
            "R1 reset state", {rdy_o, cke_o, odt_o, clk_chg_ok_o, cmd_vld_o, ack_o, rej_o}, 96);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdy_o && cke_o && !cmd_vld_o, "R1 after release", {rdy_o, cke_o, cmd_vld_o}, 6);

        for (int i = 0; i < NV; i++) begin
            run_seq(VECS[i], 1'b0, 1'b0);
        end

        odt_i = 1'b1;
        @(negedge clk);
        chk(odt_o, "R12 odt follows", odt_o, 1);
        run_seq('{tgt: 12'd900, path: 1'b1, ten: 8'd6, tsx: 8'd3, txp: 8'd1, tlk: 8'd4, rej: 1'b0}, 1'b1, 1'b0);
        chk(odt_o, "R12 odt after sequence", odt_o, 1);
        odt_i = 1'b0;
        @(negedge clk);
        chk(!odt_o, "R12 odt low", odt_o, 0);

        run_seq('{tgt: 12'd600, path: 1'b0, ten: 8'd2, tsx: 8'd5, txp: 8'd3, tlk: 8'd2, rej: 1'b0}, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule